// File: doc/BRIEF.md
# Floating-point exception trap unit

This block sits beside a 64-bit floating-point datapath and owns its exception state. It screens double-format source operands before an operation starts and raises a trap for operands the instruction may not consume. After an operation it takes the six exception flags that the arithmetic reports. It folds those flags into a sticky status register and decides whether the instruction traps.

Each instruction comes with its own ignore mask. Instructions marked for software completion follow different rules: ignored flags are never recorded, and the trap summary carries only the flags that are enabled. A trap leaves the block as a single-cycle pulse. The pulse carries a summary word and a one-hot mask that names the destination register. The enable mask and the flush-inputs-to-zero control come from configuration registers elsewhere, and the block samples them in the cycle it accepts a check or a report.

Flag bit positions, used by the sticky register, the flag, ignore and enable inputs: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact, bit 5 integer overflow. In the summary word, bit 0 is the software-completion bit and bits 6:1 hold the flags in that same order. Check modes are: 0 normal, 1 compare, 2 software completion. Mode 3 behaves as normal.

Top module: `fp_trap_unit`

## Requirements
- R1: While reset is active, and on the first cycle after it, the sticky register reads 0 and trap_valid_o is low.
- R2: A report without software completion ORs every raised flag into the sticky register, even ignored ones. It traps when flags & ~ignore is nonzero. The summary then holds flags & ~ignore in bits 6:1, and bit 0 is 0. The enable mask has no effect.
- R3: A report with software completion ORs only flags & ~ignore into the sticky register. It traps when flags & ~ignore is nonzero, even if the enable mask clears every bit. The summary holds (flags & ~ignore & enable) in bits 6:1, and bit 0 is 1.
- R4: A report trap sets trap_regmask_o to 1 << rep_reg_i, with exactly one bit set. An operand-check trap drives the mask to 0.
- R5: A normal check with exponent 0 and fraction nonzero traps with summary 7'b0000010 and leaves the sticky register unchanged. An all-ones exponent (infinity or NaN) traps with the same summary and sets sticky bit 0.
- R6: A compare check behaves like a normal check, except that infinity (all-ones exponent, fraction 0) passes without a trap or a sticky change. A NaN traps and sets sticky bit 0.
- R7: A software-completion check traps with summary 7'b0000011 when the exponent is 0 and the fraction is nonzero, whatever the sign. It never traps when cfg_flush_i is 1, never touches the sticky register, and accepts infinities and NaNs.
- R8: A zero operand of either sign never traps in any check mode.
- R9: When a check and a report arrive in the same cycle, both update the sticky register. A check trap takes the trap output; otherwise the report decides it.
- R10: The trap output and the sticky update appear on the clock edge that accepts the request. trap_valid_o is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_enable_i | input | 6 | Trap enable mask for software-completion reports |
| cfg_flush_i | input | 1 | Flush-inputs-to-zero control |
| chk_valid_i | input | 1 | Operand check request |
| chk_mode_i | input | 2 | Check mode: 0 normal, 1 compare, 2 software completion |
| chk_operand_i | input | 64 | Double-format operand to screen |
| rep_valid_i | input | 1 | Flag report request |
| rep_flags_i | input | 6 | Exception flags raised by the operation |
| rep_ignore_i | input | 6 | Per-instruction ignore mask |
| rep_swc_i | input | 1 | Instruction uses software completion |
| rep_reg_i | input | 5 | Destination register number |
| trap_valid_o | output | 1 | Single-cycle trap pulse |
| trap_summary_o | output | 7 | Trap summary: bit 0 software completion, bits 6:1 flags |
| trap_regmask_o | output | 32 | One-hot destination register mask |
| sticky_o | output | 6 | Sticky exception status |

## Verification
The hardest case to reach is a software-completion report where every unignored flag is masked by the enable mask. In that case the block must still trap, but its summary holds only the completion bit. A second hard case is an ignored flag that must reach the sticky register in one mode and must not reach it in the other. Both depend on the sticky register not already holding that bit. The bench therefore resets before these directed cases and picks flags and masks that do not overlap. The random phase then draws operands from classes weighted toward zero, all-ones and denormal exponents, and it sometimes sends a check and a report in the same cycle.

// File: rtl/fp_trap_pkg.sv
package fp_trap_pkg;
  localparam int unsigned FLAG_W = 6;
  localparam int unsigned SUM_W  = FLAG_W + 1;

  localparam int unsigned F_INV = 0;
  localparam int unsigned F_DZE = 1;
  localparam int unsigned F_OVF = 2;
  localparam int unsigned F_UNF = 3;
  localparam int unsigned F_INE = 4;
  localparam int unsigned F_IOV = 5;

  typedef enum logic [1:0] {
    CHK_NORMAL = 2'd0,
    CHK_CMP    = 2'd1,
    CHK_SWC    = 2'd2,
    CHK_ALT    = 2'd3
  } chk_mode_e;
endpackage

// File: rtl/fp_operand_screen.sv
module fp_operand_screen
  import fp_trap_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned MAG_W = EXP_W + FRAC_W
) (
  input  logic [1:0]       mode_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             flush_i,
  output logic             trap_o,
  output logic             set_inv_o,
  output logic             swc_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_zero, exp_ones, frac_nz;

  assign exp_f    = mag_i[MAG_W-1:FRAC_W];
  assign frac_f   = mag_i[FRAC_W-1:0];
  assign exp_zero = ~|exp_f;
  assign exp_ones = &exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    trap_o    = 1'b0;
    set_inv_o = 1'b0;
    swc_o     = 1'b0;
    unique case (chk_mode_e'(mode_i))
      CHK_SWC: begin
        swc_o  = 1'b1;
        trap_o = exp_zero & frac_nz & ~flush_i;
      end
      CHK_CMP: begin
        set_inv_o = exp_ones & frac_nz;
        trap_o    = (exp_zero & frac_nz) | set_inv_o;
      end
      default: begin
        set_inv_o = exp_ones;
        trap_o    = (exp_zero & frac_nz) | exp_ones;
      end
    endcase
  end
endmodule

// File: rtl/fp_flag_resolve.sv
module fp_flag_resolve
  import fp_trap_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] ignore_i,
  input  logic [FLAG_W-1:0] enable_i,
  input  logic              swc_i,
  output logic [FLAG_W-1:0] sticky_add_o,
  output logic              trap_o,
  output logic [FLAG_W-1:0] trap_flags_o
);
  logic [FLAG_W-1:0] kept;

  assign kept         = flags_i & ~ignore_i;
  assign sticky_add_o = swc_i ? kept : flags_i;
  // software completion traps on any kept flag, but reports only enabled ones
  assign trap_o       = |kept;
  assign trap_flags_o = swc_i ? (kept & enable_i) : kept;
endmodule

// File: rtl/fp_trap_unit.sv
module fp_trap_unit
  import fp_trap_pkg::*;
#(
  parameter int unsigned EXP_W    = 11,
  parameter int unsigned FRAC_W   = 52,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned OP_W    = EXP_W + FRAC_W + 1,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] cfg_enable_i,
  input  logic              cfg_flush_i,
  input  logic              chk_valid_i,
  input  logic [1:0]        chk_mode_i,
  input  logic [OP_W-1:0]   chk_operand_i,
  input  logic              rep_valid_i,
  input  logic [FLAG_W-1:0] rep_flags_i,
  input  logic [FLAG_W-1:0] rep_ignore_i,
  input  logic              rep_swc_i,
  input  logic [REG_W-1:0]  rep_reg_i,
  output logic              trap_valid_o,
  output logic [SUM_W-1:0]  trap_summary_o,
  output logic [NUM_REGS-1:0] trap_regmask_o,
  output logic [FLAG_W-1:0] sticky_o
);
  logic chk_trap, chk_set_inv, chk_swc;
  logic [FLAG_W-1:0] rep_sticky_add, rep_trap_flags;
  logic rep_trap;
  logic [NUM_REGS-1:0] reg_dec;
  logic [FLAG_W-1:0] sticky_d;
  logic trap_d;
  logic [SUM_W-1:0] summary_d;
  logic [NUM_REGS-1:0] regmask_d;
  logic chk_fire, rep_fire;

  fp_operand_screen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_screen (
    .mode_i   (chk_mode_i),
    .mag_i    (chk_operand_i[OP_W-2:0]),
    .flush_i  (cfg_flush_i),
    .trap_o   (chk_trap),
    .set_inv_o(chk_set_inv),
    .swc_o    (chk_swc)
  );

  fp_flag_resolve i_resolve (
    .flags_i     (rep_flags_i),
    .ignore_i    (rep_ignore_i),
    .enable_i    (cfg_enable_i),
    .swc_i       (rep_swc_i),
    .sticky_add_o(rep_sticky_add),
    .trap_o      (rep_trap),
    .trap_flags_o(rep_trap_flags)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign reg_dec[g] = (rep_reg_i == REG_W'(g));
  end

  assign chk_fire = chk_valid_i & chk_trap;
  assign rep_fire = rep_valid_i & rep_trap;

  always_comb begin
    sticky_d = sticky_o;
    if (chk_valid_i && chk_set_inv) sticky_d[F_INV] = 1'b1;
    if (rep_valid_i) sticky_d = sticky_d | rep_sticky_add;
    trap_d    = chk_fire | rep_fire;
    summary_d = '0;
    regmask_d = '0;
    if (chk_fire) begin
      summary_d[F_INV+1] = 1'b1;
      summary_d[0]       = chk_swc;
    end else if (rep_fire) begin
      summary_d = {rep_trap_flags, rep_swc_i};
      regmask_d = reg_dec;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_o       <= '0;
      trap_valid_o   <= 1'b0;
      trap_summary_o <= '0;
      trap_regmask_o <= '0;
    end else begin
      sticky_o       <= sticky_d;
      trap_valid_o   <= trap_d;
      trap_summary_o <= summary_d;
      trap_regmask_o <= regmask_d;
    end
  end

  AST_STICKY_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o))); // R2
  AST_REGMASK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o |-> $onehot0(trap_regmask_o)); // R4
  AST_IDLE_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_valid_i && !rep_valid_i) |=> !trap_valid_o); // R10
  AST_PLAIN_TRAP_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_o && !trap_summary_o[0]) |-> (trap_summary_o[SUM_W-1:1] != '0)); // R2
  AST_ZERO_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && !rep_valid_i && (chk_operand_i[OP_W-2:0] == '0)
     && (chk_operand_i[OP_W-1] || !chk_operand_i[OP_W-1])) |=> !trap_valid_o); // R8
  AST_IDLE_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_valid_i && !rep_valid_i) |=> $stable(sticky_o)); // R10
endmodule

// File: tb/test_fp_trap_unit.sv
`timescale 1ns/1ps
module test_fp_trap_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] cfg_enable;
  logic cfg_flush;
  logic chk_valid;
  logic [1:0] chk_mode;
  logic [63:0] chk_operand;
  logic rep_valid;
  logic [5:0] rep_flags, rep_ignore;
  logic rep_swc;
  logic [4:0] rep_reg;
  logic trap_valid;
  logic [6:0] trap_summary;
  logic [31:0] trap_regmask;
  logic [5:0] sticky;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [5:0] m_sticky = '0;

  always #2.5 clk = ~clk;

  fp_trap_unit i_fp_trap_unit (
    .clk_i(clk), .rst_ni(rst_n), .cfg_enable_i(cfg_enable), .cfg_flush_i(cfg_flush),
    .chk_valid_i(chk_valid), .chk_mode_i(chk_mode), .chk_operand_i(chk_operand),
    .rep_valid_i(rep_valid), .rep_flags_i(rep_flags), .rep_ignore_i(rep_ignore),
    .rep_swc_i(rep_swc), .rep_reg_i(rep_reg), .trap_valid_o(trap_valid),
    .trap_summary_o(trap_summary), .trap_regmask_o(trap_regmask), .sticky_o(sticky)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // operand check model: returns trap, summary, sticky-invalid set
  function automatic void chk_model(input logic [1:0] mode, input logic [63:0] op,
                                    input logic flush, output logic t, output logic [6:0] s,
                                    output logic si);
    logic [10:0] e;
    logic fnz;
    e = op[62:52];
    fnz = (op[51:0] != 0);
    t = 0; s = 0; si = 0;
    if (mode == 2) begin
      t = (e == 0) && fnz && !flush;
      s = 7'b0000011;
    end else if (mode == 1) begin
      si = (e == 11'h7ff) && fnz;
      t = ((e == 0) && fnz) || si;
      s = 7'b0000010;
    end else begin
      si = (e == 11'h7ff);
      t = ((e == 0) && fnz) || si;
      s = 7'b0000010;
    end
  endfunction

  function automatic void rep_model(input logic [5:0] fl, input logic [5:0] ig,
                                    input logic swc, input logic [5:0] en,
                                    output logic t, output logic [6:0] s,
                                    output logic [5:0] add);
    logic [5:0] k;
    k = fl & ~ig;
    t = (k != 0);
    add = swc ? k : fl;
    s = swc ? {k & en, 1'b1} : {k, 1'b0};
  endfunction

  task automatic idle_inputs();
    chk_valid = 0; rep_valid = 0; chk_mode = 0; chk_operand = '0;
    rep_flags = 0; rep_ignore = 0; rep_swc = 0; rep_reg = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    @(negedge clk);
    check("R1 sticky in reset", 64'(sticky), 64'h0);
    check("R1 trap in reset", 64'(trap_valid), 64'h0);
    rst_n = 1;
    m_sticky = '0;
    @(negedge clk);
    check("R1 sticky after reset", 64'(sticky), 64'h0);
    check("R1 trap after reset", 64'(trap_valid), 64'h0);
  endtask

  // one transaction: drive at negedge, check at the next negedge, then go idle
  task automatic txn(input string req, input logic cv, input logic [1:0] md,
                     input logic [63:0] op, input logic rv, input logic [5:0] fl,
                     input logic [5:0] ig, input logic swc, input logic [4:0] rg,
                     input logic [5:0] en, input logic fz);
    logic ct, csi, rt, et;
    logic [6:0] cs, rs, es;
    logic [5:0] radd;
    logic [31:0] em;
    @(negedge clk);
    chk_valid = cv; chk_mode = md; chk_operand = op;
    rep_valid = rv; rep_flags = fl; rep_ignore = ig; rep_swc = swc; rep_reg = rg;
    cfg_enable = en; cfg_flush = fz;
    chk_model(md, op, fz, ct, cs, csi);
    rep_model(fl, ig, swc, en, rt, rs, radd);
    ct = ct & cv; rt = rt & rv;
    et = ct | rt;
    es = ct ? cs : (rt ? rs : 7'h0);
    em = (!ct && rt) ? (32'h1 << rg) : 32'h0;
    if (cv && csi) m_sticky[0] = 1'b1;
    if (rv) m_sticky = m_sticky | radd;
    @(negedge clk);
    check({req, " trap_valid"}, 64'(trap_valid), 64'(et));
    if (et) begin
      check({req, " summary"}, 64'(trap_summary), 64'(es));
      check({req, " regmask R4"}, 64'(trap_regmask), 64'(em));
    end
    check({req, " sticky"}, 64'(sticky), 64'(m_sticky));
    idle_inputs();
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R10 pulse ends", 64'(trap_valid), 64'h0);
  endtask

  localparam logic [63:0] DENORM  = 64'h0000_0000_0000_0123;
  localparam logic [63:0] NDENORM = 64'h8000_0000_0000_0001;
  localparam logic [63:0] INF     = 64'h7ff0_0000_0000_0000;
  localparam logic [63:0] NAN     = 64'h7ff8_0000_0000_0001;
  localparam logic [63:0] ONE     = 64'h3ff0_0000_0000_0000;
  localparam logic [63:0] NZERO   = 64'h8000_0000_0000_0000;

  initial begin
    void'($urandom(32'd4242));
    idle_inputs();
    cfg_enable = 0; cfg_flush = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    do_reset();

    // R5 normal check
    txn("R5 denorm", 1, 2'd0, DENORM, 0, 0, 0, 0, 0, 0, 0);
    idle_check();
    txn("R5 normal value", 1, 2'd0, ONE, 0, 0, 0, 0, 0, 0, 0);
    txn("R5 infinity", 1, 2'd0, INF, 0, 0, 0, 0, 0, 0, 0);
    do_reset();
    // R6 compare check
    txn("R6 infinity passes", 1, 2'd1, INF, 0, 0, 0, 0, 0, 0, 0);
    txn("R6 denorm", 1, 2'd1, DENORM, 0, 0, 0, 0, 0, 0, 0);
    txn("R6 nan", 1, 2'd1, NAN, 0, 0, 0, 0, 0, 0, 0);
    do_reset();
    // R7 software completion check
    txn("R7 neg denorm", 1, 2'd2, NDENORM, 0, 0, 0, 0, 0, 0, 0);
    txn("R7 denorm flushed", 1, 2'd2, DENORM, 0, 0, 0, 0, 0, 0, 1);
    txn("R7 nan accepted", 1, 2'd2, NAN, 0, 0, 0, 0, 0, 0, 0);
    // R8 zeros
    for (int m = 0; m < 4; m++) begin
      txn("R8 +zero", 1, 2'(m), 64'h0, 0, 0, 0, 0, 0, 0, 0);
      txn("R8 -zero", 1, 2'(m), NZERO, 0, 0, 0, 0, 0, 0, 0);
    end
    // R2 ignored flag still sticky, enable irrelevant
    do_reset();
    txn("R2 partial ignore", 0, 0, 0, 1, 6'b010110, 6'b000110, 0, 5'd7, 6'b000000, 0);
    txn("R2 all ignored", 0, 0, 0, 1, 6'b100001, 6'b100001, 0, 5'd3, 6'b111111, 0);
    // R3 ignored flag not sticky; trap with all enables off
    do_reset();
    txn("R3 ignored not sticky", 0, 0, 0, 1, 6'b000011, 6'b000011, 1, 5'd1, 6'b111111, 0);
    txn("R3 enable zero still traps", 0, 0, 0, 1, 6'b001100, 6'b000000, 1, 5'd31, 6'b000000, 0);
    txn("R3 partial enable", 0, 0, 0, 1, 6'b110000, 6'b000000, 1, 5'd0, 6'b100000, 0);
    // R9 simultaneous
    do_reset();
    txn("R9 check wins", 1, 2'd0, INF, 1, 6'b000100, 6'b0, 0, 5'd9, 0, 0);
    txn("R9 report when check clean", 1, 2'd0, ONE, 1, 6'b001000, 6'b0, 0, 5'd12, 0, 0);
    idle_check();

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [63:0] op;
      logic [10:0] e;
      logic [51:0] f;
      int c;
      c = int'($urandom_range(0, 3));
      e = (c == 0) ? 11'h0 : (c == 1) ? 11'h7ff : 11'($urandom);
      f = ($urandom_range(0, 2) == 0) ? 52'h0 : {20'($urandom), 32'($urandom)};
      op = {1'($urandom), e, f};
      if ($urandom_range(0, 30) == 0) do_reset();
      txn("R2 R3 R4 R5 R6 R7 R9 random", 1'($urandom), 2'($urandom), op, 1'($urandom),
          6'($urandom), 6'($urandom), 1'($urandom), 5'($urandom), 6'($urandom),
          1'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule